// File: doc/BRIEF.md
# Extended Tick Counter for a Reloading Down-Counter

This block turns a 16-bit down-counter that reloads every period (rate-generator style) into a 32-bit count of elapsed input ticks that only moves forward. Whoever reads the time latches the down-counter and presents that 16-bit sample together with a read request. The block converts the sample into ticks elapsed in the current period, works out whether the counter has wrapped since the last read, and returns the elapsed value plus an accumulated 32-bit offset. Wraps show up in two ways: a sample that steps backwards, or a period interrupt that is still pending while the counter has only just restarted. A "ticked" flag records that a wrap was already counted on the read side, so that servicing the interrupt does not count it again.

The block also chooses the reload value. It divides a configured input clock rate by a desired interrupt rate, rounds to nearest, and gives the 16-bit word to program into the counter. That word is zero when the full 65536-tick period is wanted. The internal maximum count is then 0xFFFF.

Top module: `tc_extender`

## Requirements
- R1: A pulse on `cfg_load` sets the reload to (cfg_freq + floor(cfg_rate/2)) / cfg_rate, in integer division. `reload_word` and the internal maximum count change on the clock edge that samples the pulse. Without a pulse, `reload_word` keeps its value.
- R2: A reload of 65536 sets `reload_word` to 0 and the maximum count to 0xFFFF. A quotient above 65536, a quotient of 0 or a rate of 0 is treated as 65536. Any other reload R gives `reload_word` = R and maximum count R.
- R3: `rd_valid` is high exactly in the cycle after the edge that samples `rd_req`. `rd_count` is then the elapsed value plus the offset after that read. The elapsed value is (maximum count − `rd_sample`) modulo 2^16, and it becomes the stored last value.
- R4: When a read's elapsed value is less than the stored last value, the read adds the maximum count to the offset and sets the ticked flag.
- R5: When `irq_pending` is high, the ticked flag is clear and the elapsed value is "near", the read adds the maximum count and sets the ticked flag. While the flag is set, a pending interrupt adds nothing more.
- R6: Near means the elapsed value is below 20, or `irq_masked` is high and the elapsed value is below floor(maximum count / 2). Otherwise a pending interrupt has no effect on the read.
- R7: On `irq_serviced`, a set ticked flag is cleared and the offset is unchanged. If the flag is clear, the maximum count is added to the offset and the stored last value becomes 0.
- R8: If `rd_req` and `irq_serviced` fall in the same cycle, the read is evaluated first and its count is returned. The service rule then applies to the state that read left behind.
- R9: The offset and `rd_count` wrap modulo 2^32.
- R10: Reset (synchronous, active high) clears the offset, the last value and the ticked flag. It sets the reload to 65536 (`reload_word` 0) and deasserts `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Recompute reload from rate inputs |
| cfg_freq | input | 32 | Counter input clock rate |
| cfg_rate | input | 32 | Desired period interrupt rate |
| reload_word | output | 16 | Value to program into the down-counter |
| rd_req | input | 1 | Read request with a latched sample |
| rd_sample | input | 16 | Latched down-counter value |
| irq_pending | input | 1 | Period interrupt is pending |
| irq_masked | input | 1 | Interrupts are masked at read time |
| irq_serviced | input | 1 | Period interrupt handler strobe |
| rd_valid | output | 1 | Returned count is valid |
| rd_count | output | 32 | Extended elapsed tick count |

## Verification
Reads are tried with samples that fall steadily within one period, which should add nothing to the offset. A sample that steps backwards shows the wrap-by-order path. Pending-interrupt reads use small elapsed values, mid-period values with interrupts masked, and the same values unmasked, which shows the near test apart from a plain pending flag. Service strobes come with the ticked flag both set and clear, and once in the same cycle as a wrapping read, which exposes double counting and the order of the two. A long run of service strobes at the full period pushes the offset past 2^32, and divisor inputs cover rounding up, rounding down and clamping to the full period.

// File: rtl/tc_ext_pkg.sv
package tc_ext_pkg;

    localparam int CNT_W  = 16;
    localparam int OUT_W  = 32;
    localparam int FREQ_W = 32;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [OUT_W-1:0] acc_t;

    // Result of converting one latched sample
    typedef struct packed {
        cnt_t elapsed;
        logic near;
    } conv_t;

    // Read-side extension state
    typedef struct packed {
        acc_t offset;
        cnt_t last;
        logic ticked;
    } ext_state_t;

    // Rounded division; zero divisor yields the largest value (full period)
    function automatic logic [FREQ_W:0] round_div(input logic [FREQ_W-1:0] f,
                                                  input logic [FREQ_W-1:0] r);
        logic [FREQ_W:0] num;
        if (r == '0) return '1;
        num = {1'b0, f} + {2'b00, r[FREQ_W-1:1]};
        return num / {1'b0, r};
    endfunction

endpackage

// File: rtl/tc_reload_select.sv
module tc_reload_select
    import tc_ext_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [FREQ_W-1:0] cfg_freq,
    input  logic [FREQ_W-1:0] cfg_rate,
    output cnt_t              reload_word,
    output cnt_t              max_count
);
    localparam logic [FREQ_W:0] FULL = (FREQ_W+1)'(1) << CNT_W;

    logic [FREQ_W:0] quot;
    logic            full_period;

    always_comb begin
        quot        = round_div(cfg_freq, cfg_rate);
        full_period = (quot >= FULL) || (quot == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_word <= '0;
            max_count   <= '1;
        end else if (cfg_load) begin
            reload_word <= full_period ? cnt_t'(0) : quot[CNT_W-1:0];
            max_count   <= full_period ? '1 : quot[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/tc_sample_conv.sv
module tc_sample_conv
    import tc_ext_pkg::*;
#(
    parameter int NEAR_LIMIT = 20
) (
    input  cnt_t  sample,
    input  cnt_t  max_count,
    input  logic  irq_masked,
    output conv_t conv
);
    cnt_t half;

    always_comb begin
        half         = max_count >> 1;
        conv.elapsed = max_count - sample;
        conv.near    = (conv.elapsed < cnt_t'(NEAR_LIMIT)) ||
                       (irq_masked && (conv.elapsed < half));
    end
endmodule

// File: rtl/tc_offset_acc.sv
module tc_offset_acc
    import tc_ext_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_req,
    input  logic  irq_pending,
    input  logic  irq_serviced,
    input  conv_t conv,
    input  cnt_t  max_count,
    output logic  rd_valid,
    output acc_t  rd_count,
    output logic  ticked,
    output acc_t  offset
);
    ext_state_t st_q, st_rd, st_d;
    acc_t       count_d;
    acc_t       step;
    logic       wrap;

    always_comb begin
        step    = acc_t'(max_count);
        st_rd   = st_q;
        count_d = rd_count;
        wrap    = (conv.elapsed < st_q.last) ||
                  (!st_q.ticked && irq_pending && conv.near);
        // Read stage first
        if (rd_req) begin
            if (wrap) begin
                st_rd.offset = st_q.offset + step;
                st_rd.ticked = 1'b1;
            end
            st_rd.last = conv.elapsed;
            count_d    = acc_t'(conv.elapsed) + st_rd.offset;
        end
        // Service stage applies to what the read left
        st_d = st_rd;
        if (irq_serviced) begin
            if (st_rd.ticked) begin
                st_d.ticked = 1'b0;
            end else begin
                st_d.offset = st_rd.offset + step;
                st_d.last   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            rd_valid <= 1'b0;
            rd_count <= '0;
        end else begin
            st_q     <= st_d;
            rd_valid <= rd_req;
            rd_count <= count_d;
        end
    end

    assign ticked = st_q.ticked;
    assign offset = st_q.offset;
endmodule

// File: rtl/tc_extender.sv
module tc_extender
    import tc_ext_pkg::*;
#(
    parameter int NEAR_LIMIT = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_load,
    input  logic [31:0] cfg_freq,
    input  logic [31:0] cfg_rate,
    output logic [15:0] reload_word,
    input  logic        rd_req,
    input  logic [15:0] rd_sample,
    input  logic        irq_pending,
    input  logic        irq_masked,
    input  logic        irq_serviced,
    output logic        rd_valid,
    output logic [31:0] rd_count
);
    cnt_t  max_w;
    conv_t conv_w;
    logic  ticked_w;
    acc_t  offset_w;

    tc_reload_select u_reload (
        .clk        (clk),
        .rst        (rst),
        .cfg_load   (cfg_load),
        .cfg_freq   (cfg_freq),
        .cfg_rate   (cfg_rate),
        .reload_word(reload_word),
        .max_count  (max_w)
    );

    tc_sample_conv #(.NEAR_LIMIT(NEAR_LIMIT)) u_conv (
        .sample    (rd_sample),
        .max_count (max_w),
        .irq_masked(irq_masked),
        .conv      (conv_w)
    );

    tc_offset_acc u_acc (
        .clk         (clk),
        .rst         (rst),
        .rd_req      (rd_req),
        .irq_pending (irq_pending),
        .irq_serviced(irq_serviced),
        .conv        (conv_w),
        .max_count   (max_w),
        .rd_valid    (rd_valid),
        .rd_count    (rd_count),
        .ticked      (ticked_w),
        .offset      (offset_w)
    );
endmodule

// File: rtl/tc_extender_checker.sv
module tc_extender_checker
    import tc_ext_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic cfg_load,
    input cnt_t reload_word,
    input logic rd_req,
    input logic irq_serviced,
    input logic rd_valid,
    input logic ticked,
    input acc_t offset,
    input cnt_t max_count
);
    assert_valid_after_req_R3: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

    assert_no_valid_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);

    assert_reload_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> $stable(reload_word));

    assert_service_clears_tick_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_serviced && !rd_req && ticked) |=> (!ticked && $stable(offset)));

    assert_service_adds_period_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_serviced && !rd_req && !ticked) |=>
            (offset == $past(offset) + acc_t'($past(max_count))));

    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (!rd_valid && !ticked && offset == '0 && reload_word == '0));
endmodule

bind tc_extender tc_extender_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_load    (cfg_load),
    .reload_word (reload_word),
    .rd_req      (rd_req),
    .irq_serviced(irq_serviced),
    .rd_valid    (rd_valid),
    .ticked      (ticked_w),
    .offset      (offset_w),
    .max_count   (max_w)
);

// File: tb/tc_extender_bench.sv
module tc_extender_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_load;
    logic [31:0] cfg_freq, cfg_rate;
    logic [15:0] reload_word;
    logic        rd_req;
    logic [15:0] rd_sample;
    logic        irq_pending, irq_masked, irq_serviced;
    logic        rd_valid;
    logic [31:0] rd_count;

    int n_chk = 0;
    int n_bad = 0;

    // Reference state, from the requirements
    logic [15:0] m_max;
    logic [31:0] m_off;
    logic [15:0] m_last;
    logic        m_ticked;

    always #5 clk = ~clk;

    tc_extender u_tc_extender (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_freq(cfg_freq),
        .cfg_rate(cfg_rate), .reload_word(reload_word), .rd_req(rd_req),
        .rd_sample(rd_sample), .irq_pending(irq_pending), .irq_masked(irq_masked),
        .irq_serviced(irq_serviced), .rd_valid(rd_valid), .rd_count(rd_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_read(input logic [15:0] s, input logic pend, input logic mask,
                              output logic [31:0] exp);
        logic [15:0] e;
        logic near;
        e    = m_max - s;
        near = (e < 16'd20) || (mask && (e < (m_max >> 1)));
        if ((e < m_last) || (!m_ticked && pend && near)) begin
            m_off    = m_off + {16'd0, m_max};
            m_ticked = 1'b1;
        end
        m_last = e;
        exp    = {16'd0, e} + m_off;
    endtask

    task automatic model_service();
        if (m_ticked) m_ticked = 1'b0;
        else begin
            m_off  = m_off + {16'd0, m_max};
            m_last = '0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_load = 0; rd_req = 0; irq_pending = 0;
        irq_masked = 0; irq_serviced = 0; rd_sample = '0;
        cfg_freq = '0; cfg_rate = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_max = 16'hFFFF; m_off = '0; m_last = '0; m_ticked = 1'b0;
    endtask

    task automatic do_cfg(input logic [31:0] f, input logic [31:0] r,
                          input logic [15:0] exp_word, input logic [15:0] exp_max, input string req);
        @(negedge clk);
        cfg_freq = f; cfg_rate = r; cfg_load = 1'b1;
        @(posedge clk); #1;
        check(req, {16'd0, reload_word}, {16'd0, exp_word});
        @(negedge clk);
        cfg_load = 1'b0;
        m_max = exp_max;
    endtask

    task automatic do_read(input logic [15:0] s, input logic pend, input logic mask,
                           input logic svc, input string req);
        logic [31:0] exp;
        @(negedge clk);
        rd_req = 1'b1; rd_sample = s; irq_pending = pend; irq_masked = mask;
        irq_serviced = svc;
        model_read(s, pend, mask, exp);
        if (svc) model_service();
        @(posedge clk); #1;
        check({req, " valid"}, {31'd0, rd_valid}, 32'd1);
        check(req, rd_count, exp);
        @(negedge clk);
        rd_req = 1'b0; irq_pending = 1'b0; irq_masked = 1'b0; irq_serviced = 1'b0;
        check({req, " valid drop"}, {31'd0, rd_valid}, 32'd1);
        @(posedge clk); #1;
        check({req, " valid low"}, {31'd0, rd_valid}, 32'd0);
    endtask

    task automatic do_service(input int n);
        @(negedge clk);
        irq_serviced = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_service();
        end
        @(negedge clk);
        irq_serviced = 1'b0;
    endtask

    // R10: reset state
    task automatic t_reset();
        do_reset();
        check("R10 reload_word", {16'd0, reload_word}, 32'd0);
        check("R10 valid", {31'd0, rd_valid}, 32'd0);
        do_read(16'hFFFF, 1'b0, 1'b0, 1'b0, "R10 zero count");
        check("R2 full period count", rd_count, 32'd0);
    endtask

    // R1 and R2: divisor selection
    task automatic t_divisor();
        do_cfg(32'd2457600, 32'd100, 16'd24576, 16'd24576, "R1 exact");
        do_cfg(32'd10, 32'd4, 16'd3, 16'd3, "R1 round up");
        do_cfg(32'd9, 32'd4, 16'd2, 16'd2, "R1 round down");
        do_cfg(32'd1000000, 32'd1, 16'd0, 16'hFFFF, "R2 clamp");
        do_read(16'hFFF0, 1'b0, 1'b0, 1'b0, "R2 max 0xFFFF");
        do_cfg(32'd5, 32'd0, 16'd0, 16'hFFFF, "R2 zero rate");
        do_cfg(32'd65536, 32'd1, 16'd0, 16'hFFFF, "R2 exactly 65536");
    endtask

    // R3, R4, R7: steady reads, backward wrap, service
    task automatic t_wrap_order();
        do_reset();
        do_cfg(32'd100000, 32'd100, 16'd1000, 16'd1000, "R1 period 1000");
        do_read(16'd900, 1'b0, 1'b0, 1'b0, "R3 in period");
        check("R3 literal", rd_count, 32'd100);
        do_read(16'd500, 1'b0, 1'b0, 1'b0, "R3 later");
        do_read(16'd950, 1'b0, 1'b0, 1'b0, "R4 backward");
        check("R4 literal", rd_count, 32'd1050);
        do_service(1);
        do_read(16'd900, 1'b0, 1'b0, 1'b0, "R7 ticked clear no add");
        check("R7 literal", rd_count, 32'd1100);
        do_service(1);
        do_read(16'd990, 1'b0, 1'b0, 1'b0, "R7 add period");
        check("R7 literal add", rd_count, 32'd2010);
    endtask

    // R5, R6: pending interrupt near and far
    task automatic t_pending();
        do_read(16'd985, 1'b1, 1'b0, 1'b0, "R5 pending near");
        check("R5 literal", rd_count, 32'd3015);
        do_read(16'd983, 1'b1, 1'b0, 1'b0, "R5 no double");
        check("R5 literal hold", rd_count, 32'd3017);
        do_service(1);
        do_read(16'd500, 1'b1, 1'b0, 1'b0, "R6 pending far unmasked");
        check("R6 literal far", rd_count, 32'd3500);
        do_read(16'd400, 1'b1, 1'b1, 1'b0, "R6 masked above half");
        check("R6 literal above half", rd_count, 32'd3600);
        do_service(1);
        do_read(16'd700, 1'b1, 1'b1, 1'b0, "R6 masked below half");
        check("R6 literal masked", rd_count, 32'd5300);
        do_service(1);
    endtask

    // R8: read and service in one cycle
    task automatic t_same_cycle();
        do_read(16'd800, 1'b0, 1'b0, 1'b0, "R8 setup");
        do_read(16'd950, 1'b0, 1'b0, 1'b1, "R8 read then service");
        do_read(16'd900, 1'b0, 1'b0, 1'b0, "R8 after");
        check("R8 no double", rd_count, m_off + 32'd100);
        do_read(16'd850, 1'b0, 1'b0, 1'b1, "R8 service adds after read");
        do_read(16'd990, 1'b0, 1'b0, 1'b0, "R8 last cleared");
    endtask

    // R9: modulo 2^32
    task automatic t_modulo();
        do_reset();
        do_service(65538);
        do_read(16'hFFFF, 1'b0, 1'b0, 1'b0, "R9 wrap");
        check("R9 literal", rd_count, 32'd65534);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_divisor();
        t_wrap_order();
        t_pending();
        t_same_cycle();
        t_modulo();
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule